// File: doc/BRIEF.md
# Power Partition Gating Controller

This block controls up to 32 switchable power partitions from a small register bus. Each partition has three controls: a power-enable, an isolation clamp and a reset. It also has a clock-enable. Software flips a partition's power state by writing its ID to a toggle register, and it reads back which partitions are powered. Clamps are released through a write-one mask register. Two configurable partition IDs can have their clamp bit positions crossed in that mask.

When the graphics clamp option is enabled, one partition's clamp is not controlled by the shared mask. It has a dedicated one-bit register in which 0 means released. A hardware sequencer can also bring a single partition fully up on command. The sequencer works in this order:

1. Assert reset.
2. Power on.
3. Enable the clock.
4. Wait a programmed number of cycles.
5. Release the clamp.
6. Wait the same number of cycles again.
7. Deassert reset.

The bus has an address, write data, a write strobe and combinational read data. Writes take effect at the clock edge that samples the strobe.

Top module: `pgate_top`

## Requirements
- R1: After reset, every partition is unpowered, clamped, held in reset and has its clock disabled. The wait register reads 10 x CLK_MHZ (40 by default) and the busy bit reads 0.
- R2: A write to address 0 with bit 8 set and a partition ID in bits 4:0 flips that partition's power state. Address 1 reads one bit per partition, where 1 means powered.
- R3: A toggle write with bit 8 clear, or with an ID of NUM_PART or more, changes no power state.
- R4: A write to address 2 releases the clamp of each partition whose mask bit is 1 and leaves all others unchanged. Reading address 2 returns the clamp vector, where 1 means clamped.
- R5: With SWAP_EN set, mask bit SWAP_A releases partition SWAP_B and mask bit SWAP_B releases partition SWAP_A.
- R6: With GFX_EN set, the clamp of partition GFX_ID follows bit 0 of writes to address 3, where 0 means released. The mask at address 2 has no effect on that clamp.
- R7: When a partition's power is toggled off, its clamp and reset are asserted and its clock is disabled on the same edge.
- R8: A sequencer command is a write to address 4 with bit 8 set and the ID in bits 4:0. It asserts reset, then powers on, then enables the clock. The clamp release follows the clock enable by W+1 cycles, and reset deassertion follows the clamp release by another W+1 cycles, where W is the wait value.
- R9: The wait register at address 5 is writable and sets W for later sequences.
- R10: Bit 0 of address 4 reads 1 while a sequence runs. It clears on the edge that deasserts the partition's reset. A sequencer command issued while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | synchronous active-low reset |
| regAddr | input | 3 | register address |
| regWdata | input | 32 | write data |
| regWe | input | 1 | write strobe |
| regRdata | output | 32 | combinational read data |
| pwrOut | output | NUM_PART | power enable per partition |
| clampOut | output | NUM_PART | isolation clamp per partition (1 = clamped) |
| clkEnOut | output | NUM_PART | clock enable per partition |
| rstOut | output | NUM_PART | reset per partition (1 = in reset) |

## Verification
A single-bit mask sweep over all partitions targets the crossed clamp pair. A design that ignored the crossing would release partition 3 for mask bit 3, and the clamp vector would show the wrong partition freed. The same sweep and an all-ones mask confirm that the graphics clamp stays set; a design that merged it into the shared mask would drop it. Toggles with the go bit clear and with out-of-range IDs would flip an aliased partition in a design with loose decoding. A cycle-indexed trace of one sequence measures the gaps between clock enable, clamp release and reset release, so a wait counter that is off by one shows up directly. A command issued mid-sequence must leave its target untouched.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int ID_BITS = 5;
  localparam int GO_BIT  = 8;

  localparam logic [2:0] A_TOGGLE = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_CLAMP  = 3'd2;
  localparam logic [2:0] A_GFX    = 3'd3;
  localparam logic [2:0] A_SEQ    = 3'd4;
  localparam logic [2:0] A_WAIT   = 3'd5;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RST, SQ_PWR, SQ_CLK, SQ_WAIT1, SQ_REL, SQ_WAIT2, SQ_DONE
  } seqState_t;

  typedef struct packed {
    logic               togValid;
    logic [ID_BITS-1:0] togId;
    logic               clampWr;
    logic               gfxWr;
    logic               gfxVal;
    logic               seqRst;
    logic               seqPwr;
    logic               seqClk;
    logic               seqRel;
    logic               seqUnrst;
    logic [ID_BITS-1:0] seqId;
  } strobe_t;
endpackage

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int NUM_PART  = 8,
  parameter bit GFX_EN    = 1'b1,
  parameter int GFX_ID    = 1,
  parameter int WAIT_W    = 16,
  parameter int WAIT_INIT = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  input  logic                regWe,
  input  logic [NUM_PART-1:0] pwrState,
  input  logic [NUM_PART-1:0] clampState,
  output logic [31:0]         regRdata,
  output logic [NUM_PART-1:0] clampMask,
  output strobe_t             stb
);
  localparam logic [ID_BITS:0] PART_LIM = (ID_BITS+1)'(NUM_PART);

  seqState_t          state;
  logic [WAIT_W-1:0]  waitQ;
  logic [WAIT_W-1:0]  cnt;
  logic [ID_BITS-1:0] seqIdQ;

  logic [ID_BITS-1:0] wrId;
  logic               idOk;
  logic               goSet;
  logic               seqAccept;
  logic               busy;

  assign wrId      = regWdata[ID_BITS-1:0];
  assign idOk      = {1'b0, wrId} < PART_LIM;
  assign goSet     = regWdata[GO_BIT];
  assign busy      = (state != SQ_IDLE);
  assign seqAccept = regWe && (regAddr == A_SEQ) && goSet && idOk && !busy;
  assign clampMask = regWdata[NUM_PART-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SQ_IDLE;
      waitQ  <= WAIT_W'(WAIT_INIT);
      cnt    <= '0;
      seqIdQ <= '0;
    end else begin
      if (regWe && regAddr == A_WAIT) waitQ <= regWdata[WAIT_W-1:0];
      case (state)
        SQ_IDLE: if (seqAccept) begin
          state  <= SQ_RST;
          seqIdQ <= wrId;
        end
        SQ_RST:  state <= SQ_PWR;
        SQ_PWR:  state <= SQ_CLK;
        SQ_CLK: begin
          state <= SQ_WAIT1;
          cnt   <= waitQ;
        end
        SQ_WAIT1: if (cnt <= 1) state <= SQ_REL; else cnt <= cnt - 1'b1;
        SQ_REL: begin
          state <= SQ_WAIT2;
          cnt   <= waitQ;
        end
        SQ_WAIT2: if (cnt <= 1) state <= SQ_DONE; else cnt <= cnt - 1'b1;
        SQ_DONE:  state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.togValid = regWe && (regAddr == A_TOGGLE) && goSet && idOk;
    stb.togId    = wrId;
    stb.clampWr  = regWe && (regAddr == A_CLAMP);
    stb.gfxWr    = GFX_EN && regWe && (regAddr == A_GFX);
    stb.gfxVal   = regWdata[0];
    stb.seqId    = seqIdQ;
    stb.seqRst   = (state == SQ_RST);
    stb.seqPwr   = (state == SQ_PWR);
    stb.seqClk   = (state == SQ_CLK);
    stb.seqRel   = (state == SQ_REL);
    stb.seqUnrst = (state == SQ_DONE);
  end

  always_comb begin
    case (regAddr)
      A_STATUS: regRdata = 32'(pwrState);
      A_CLAMP:  regRdata = 32'(clampState);
      A_GFX:    regRdata = GFX_EN ? {31'b0, clampState[GFX_ID]} : 32'b0;
      A_SEQ:    regRdata = {31'b0, busy};
      A_WAIT:   regRdata = 32'(waitQ);
      default:  regRdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/pgate_datapath.sv
module pgate_datapath
  import pgate_pkg::*;
#(
  parameter int NUM_PART = 8,
  parameter bit GFX_EN   = 1'b1,
  parameter int GFX_ID   = 1,
  parameter bit SWAP_EN  = 1'b1,
  parameter int SWAP_A   = 3,
  parameter int SWAP_B   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [NUM_PART-1:0] clampMask,
  output logic [NUM_PART-1:0] pwrOut,
  output logic [NUM_PART-1:0] clampOut,
  output logic [NUM_PART-1:0] clkEnOut,
  output logic [NUM_PART-1:0] rstOut
);
  for (genvar i = 0; i < NUM_PART; i++) begin : g_part
    localparam int SRC = (SWAP_EN && i == SWAP_A) ? SWAP_B :
                         (SWAP_EN && i == SWAP_B) ? SWAP_A : i;
    logic togHit, seqHit, seqOn, offNow;

    assign togHit = stb.togValid && (stb.togId == ID_BITS'(i));
    assign seqHit = (stb.seqId == ID_BITS'(i));
    assign seqOn  = seqHit && stb.seqPwr;
    assign offNow = togHit && pwrOut[i] && !seqOn;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pwrOut[i]   <= 1'b0;
        clkEnOut[i] <= 1'b0;
        rstOut[i]   <= 1'b1;
      end else begin
        if (seqOn) pwrOut[i] <= 1'b1;
        else if (togHit) pwrOut[i] <= ~pwrOut[i];
        if (offNow) clkEnOut[i] <= 1'b0;
        else if (seqHit && stb.seqClk) clkEnOut[i] <= 1'b1;
        if (offNow || (seqHit && stb.seqRst)) rstOut[i] <= 1'b1;
        else if (seqHit && stb.seqUnrst) rstOut[i] <= 1'b0;
      end
    end

    if (GFX_EN && i == GFX_ID) begin : g_gfx
      always_ff @(posedge clk) begin
        if (!rstN) clampOut[i] <= 1'b1;
        else if (offNow) clampOut[i] <= 1'b1;
        else if (stb.gfxWr) clampOut[i] <= stb.gfxVal;
        else if (seqHit && stb.seqRel) clampOut[i] <= 1'b0;
      end
    end else begin : g_std
      always_ff @(posedge clk) begin
        if (!rstN) clampOut[i] <= 1'b1;
        else if (offNow) clampOut[i] <= 1'b1;
        else if ((stb.clampWr && clampMask[SRC]) || (seqHit && stb.seqRel))
          clampOut[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgate_top.sv
module pgate_top
  import pgate_pkg::*;
#(
  parameter int NUM_PART = 8,
  parameter bit GFX_EN   = 1'b1,
  parameter int GFX_ID   = 1,
  parameter bit SWAP_EN  = 1'b1,
  parameter int SWAP_A   = 3,
  parameter int SWAP_B   = 4,
  parameter int CLK_MHZ  = 4,
  parameter int WAIT_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  input  logic                regWe,
  output logic [31:0]         regRdata,
  output logic [NUM_PART-1:0] pwrOut,
  output logic [NUM_PART-1:0] clampOut,
  output logic [NUM_PART-1:0] clkEnOut,
  output logic [NUM_PART-1:0] rstOut
);
  localparam int WAIT_INIT = 10 * CLK_MHZ;

  strobe_t             stb;
  logic [NUM_PART-1:0] clampMask;

  pgate_ctrl #(
    .NUM_PART(NUM_PART), .GFX_EN(GFX_EN), .GFX_ID(GFX_ID),
    .WAIT_W(WAIT_W), .WAIT_INIT(WAIT_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .pwrState(pwrOut), .clampState(clampOut),
    .regRdata(regRdata), .clampMask(clampMask), .stb(stb)
  );

  pgate_datapath #(
    .NUM_PART(NUM_PART), .GFX_EN(GFX_EN), .GFX_ID(GFX_ID),
    .SWAP_EN(SWAP_EN), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .clampMask(clampMask),
    .pwrOut(pwrOut), .clampOut(clampOut), .clkEnOut(clkEnOut), .rstOut(rstOut)
  );
endmodule

// File: rtl/pgate_chk.sv
module pgate_chk #(
  parameter int NUM_PART = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PART-1:0] pwrOut,
  input logic [NUM_PART-1:0] clampOut,
  input logic [NUM_PART-1:0] clkEnOut,
  input logic [NUM_PART-1:0] rstOut
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (pwrOut == '0 && clampOut == '1 && rstOut == '1 && clkEnOut == '0));

  // R2
  single_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pwrOut ^ $past(pwrOut)) <= 1);

  // R7
  off_reclamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pwrOut) & ~pwrOut) & (~clampOut | ~rstOut | clkEnOut)) == '0);

  // R8
  unreset_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rstOut) & ~rstOut) & (clampOut | ~clkEnOut | ~pwrOut)) == '0);

  // R8
  clk_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(clkEnOut) & clkEnOut) & ~rstOut) == '0);
endmodule

bind pgate_top pgate_chk #(.NUM_PART(NUM_PART)) u_chk (
  .clk(clk), .rstN(rstN), .pwrOut(pwrOut), .clampOut(clampOut),
  .clkEnOut(clkEnOut), .rstOut(rstOut)
);

// File: tb/test_pgate_top.sv
module test_pgate_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int GFX = 1;
  localparam int SA = 3;
  localparam int SB = 4;
  localparam logic [NP-1:0] ALL = '1;

  logic clk = 0;
  logic rstN = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWdata = 0;
  logic regWe = 0;
  logic [31:0] regRdata;
  logic [NP-1:0] pwrOut, clampOut, clkEnOut, rstOut;

  int checks = 0;
  int errors = 0;

  pgate_top #(.NUM_PART(NP), .GFX_ID(GFX), .SWAP_A(SA), .SWAP_B(SB), .CLK_MHZ(4))
    i_pgate_top (
      .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
      .regWe(regWe), .regRdata(regRdata), .pwrOut(pwrOut),
      .clampOut(clampOut), .clkEnOut(clkEnOut), .rstOut(rstOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int n = 0; n < 500; n++) begin
      rd(3'd4, v);
      if (v[0] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  function automatic int swapOf(int k);
    return (k == SA) ? SB : (k == SB) ? SA : k;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nPwr, nClk, nRel, nUn;
    logic busyAtUn, busyBefore;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwr", 32'(pwrOut), 0);
    chk("R1 clamp", 32'(clampOut), 32'(ALL));
    chk("R1 rst", 32'(rstOut), 32'(ALL));
    chk("R1 clk", 32'(clkEnOut), 0);
    rd(3'd5, v); chk("R1 wait default", v, 40);
    rd(3'd4, v); chk("R1 busy", v, 0);

    // R2 toggle sweep
    for (int id = 0; id < NP; id++) begin
      wr(3'd0, 32'h100 | 32'(id));
      rd(3'd1, v); chk("R2 on", v, 32'(1) << id);
      wr(3'd0, 32'h100 | 32'(id));
      rd(3'd1, v); chk("R2 off", v, 0);
    end

    // R3 ignored toggles
    wr(3'd0, 32'd2);
    rd(3'd1, v); chk("R3 no go bit", v, 0);
    wr(3'd0, 32'h100 | 32'd8);
    rd(3'd1, v); chk("R3 id=NUM_PART", v, 0);
    wr(3'd0, 32'h100 | 32'd31);
    rd(3'd1, v); chk("R3 id=31", v, 0);

    // R4 R5 R6 clamp mask sweep, R7 re-clamp on power off
    for (int k = 0; k < NP; k++) begin
      int p;
      logic [NP-1:0] exp;
      p = swapOf(k);
      exp = (p == GFX) ? ALL : (ALL & ~(NP'(1) << p));
      wr(3'd2, 32'(1) << k);
      rd(3'd2, v);
      chk((p == GFX) ? "R6 mask ignores gfx" : (p != k) ? "R5 swapped" : "R4 release",
          v, 32'(exp));
      wr(3'd0, 32'h100 | 32'(p));
      wr(3'd0, 32'h100 | 32'(p));
      chk("R7 reclamp", 32'(clampOut), 32'(ALL));
      chk("R7 reset", 32'(rstOut), 32'(ALL));
    end
    wr(3'd2, 32'hFF);
    chk("R4 R6 full mask", 32'(clampOut), 32'(NP'(1) << GFX));
    for (int k = 0; k < NP; k++) begin
      wr(3'd0, 32'h100 | 32'(k));
      wr(3'd0, 32'h100 | 32'(k));
    end
    chk("R7 all reclamped", 32'(clampOut), 32'(ALL));

    // R6 dedicated graphics clamp, 0 = released
    wr(3'd3, 32'd0);
    chk("R6 gfx release", 32'(clampOut), 32'(ALL & ~(NP'(1) << GFX)));
    rd(3'd3, v); chk("R6 gfx read", v, 0);
    wr(3'd3, 32'd1);
    chk("R6 gfx reclamp", 32'(clampOut), 32'(ALL));

    // R9 program wait, R8 cycle trace on partition 5
    wr(3'd5, 32'd5);
    rd(3'd5, v); chk("R9 wait write", v, 5);
    wr(3'd4, 32'h100 | 32'd5);
    nPwr = -1; nClk = -1; nRel = -1; nUn = -1; busyAtUn = 1; busyBefore = 0;
    regAddr = 3'd4;
    for (int c = 0; c < 30; c++) begin
      #1;
      if (nPwr < 0 && pwrOut[5]) nPwr = c;
      if (nClk < 0 && clkEnOut[5]) nClk = c;
      if (nRel < 0 && !clampOut[5]) nRel = c;
      if (nUn < 0 && !rstOut[5]) begin nUn = c; busyAtUn = regRdata[0]; end
      if (c == 14) busyBefore = regRdata[0];
      @(negedge clk);
    end
    chk("R8 power before clock", 32'(nPwr), 2);
    chk("R8 clock edge", 32'(nClk), 3);
    chk("R8 clamp gap W+1", 32'(nRel - nClk), 6);
    chk("R8 reset gap W+1", 32'(nUn - nRel), 6);
    chk("R10 busy during", 32'(busyBefore), 1);
    chk("R10 busy clears with reset", 32'(busyAtUn), 0);
    chk("R8 final pwr", 32'(pwrOut), 32'h20);

    // R10 command while busy is dropped
    wr(3'd5, 32'd3);
    wr(3'd4, 32'h100 | 32'd2);
    wr(3'd4, 32'h100 | 32'd6);
    waitIdle();
    chk("R10 target pwr", 32'(pwrOut[2]), 1);
    chk("R10 dropped pwr", 32'(pwrOut[6]), 0);
    chk("R10 dropped rst", 32'(rstOut[6]), 1);
    @(negedge clk);
    rd(3'd4, v); chk("R10 stays idle", v, 0);

    // R6 R8 sequencer releases graphics clamp
    wr(3'd4, 32'h100 | 32'(GFX));
    waitIdle();
    chk("R6 R8 gfx seq clamp", 32'(clampOut[GFX]), 0);
    chk("R8 gfx seq rst", 32'(rstOut[GFX]), 0);

    // R7 power-off after full bring-up
    wr(3'd0, 32'h100 | 32'd2);
    chk("R7 off pwr", 32'(pwrOut[2]), 0);
    chk("R7 off clamp", 32'(clampOut[2]), 1);
    chk("R7 off rst", 32'(rstOut[2]), 1);
    chk("R7 off clk", 32'(clkEnOut[2]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule